// File: doc/BRIEF.md
# Sync-Realigned Sample Clock Regenerator

This block sits at every receiving node of a distributed timing network. It takes the received master clock, nominally 24.576 MHz, and a received sync event that recurs at a kHz rate. It produces a divided sample clock for delta-sigma converters, a regenerated one-period sync strobe for those converters, and a strobe that marks when their conversion result can be read.

The received sync passes through a synchroniser and an edge detector. Its rising edge then forces the divider back to the start of its high phase, so every node that sees the same sync edge on the same master clock edge holds the same divider phase. The regenerated sync is launched from the falling edge of the master clock. Its transitions therefore sit half a master period away from the rising edge, which is the edge the converters and the divider use.

A countdown starts on each realignment and runs for a parameterised number of divided clock periods (1024 by default). When it ends, a one-cycle ready strobe is raised. A fresh sync restarts the countdown.

Top module: `sync_clk_regen`

## Requirements
- R1: While rst_ni is low, div_clk_o, sync_o and data_ready_o are all low.
- R2: When not realigned, div_clk_o has a period of DIV_RATIO master cycles and is high for the first floor(DIV_RATIO/2) of them. It changes only on rising edges of clk_i. The first rising edge after reset release starts a high phase.
- R3: The bench samples sync_i at rising edge n. If it sees low at edge n-3 and high at edge n-2, edge n realigns the divider: div_clk_o goes high at edge n and a new period of DIV_RATIO cycles counts from there, whatever the previous phase was.
- R4: A sync_i held high for many cycles realigns the divider only once. The level after the rising edge has no effect on div_clk_o.
- R5: sync_o rises on the falling edge of clk_i just before the realigning rising edge n. It falls on the following falling edge, so it is exactly one master period wide and is high at edge n.
- R6: data_ready_o is high for exactly one master cycle. It goes high at the rising edge of div_clk_o that lies READY_CYCLES divided periods after the realigning edge, and it coincides with that div_clk_o rise.
- R7: A realignment during a countdown restarts it, and only the newest realignment produces a ready strobe.
- R8: data_ready_o stays low when no realignment has happened since reset. Each realignment gives at most one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Received master clock; rising edge is the active edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| sync_i | input | 1 | Received sync, asynchronous to clk_i |
| div_clk_o | output | 1 | Divided sample clock for the converters |
| sync_o | output | 1 | Regenerated sync, one master period wide, launched on the falling edge |
| data_ready_o | output | 1 | One-cycle strobe when a conversion result can be read |

## Verification
The divider is first left free-running after reset, to confirm the period and duty cycle without any sync. Single-cycle sync pulses are then applied at every divider phase offset, which separates a true phase reset from a design that waits for the next natural wrap. A sync held high for a long time tells edge detection apart from level sensitivity. Two syncs inside one countdown show whether the counter restarts or keeps its stale count. Sampling sync_o on both clock edges shows whether it is launched on the falling edge rather than the rising one.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;

  typedef enum logic {
    TMR_IDLE  = 1'b0,
    TMR_COUNT = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  // last synchronised stage high while the history stage is still low
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/phase_divider.sv
module phase_divider #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic realign_i,
  output logic div_clk_o,
  output logic wrap_o
);

  localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] HIGH_N = CW'(DIV_RATIO / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_q, div_d;

  always_comb begin
    wrap_o = (cnt_q == LAST) && !realign_i;
    if (realign_i)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
    div_d = (cnt_d < HIGH_N);
  end

  // reset parks the count on its last value so the first edge opens a high phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_clk_o = div_q;

endmodule

// File: rtl/ready_timer.sv
module ready_timer
  import sync_regen_pkg::*;
#(
  parameter int READY_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic ready_o
);

  localparam int CW = (READY_CYCLES > 2) ? $clog2(READY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(READY_CYCLES - 1);

  tmr_state_e    st_q, st_d;
  logic [CW-1:0] per_q, per_d;
  logic          rdy_q, rdy_d;
  logic          cnt_en;

  always_comb begin
    st_d   = st_q;
    per_d  = per_q;
    rdy_d  = 1'b0;
    cnt_en = (st_q == TMR_COUNT) && tick_i;
    if (restart_i) begin
      st_d  = TMR_COUNT;
      per_d = '0;
    end else if (cnt_en) begin
      if (per_q == LAST) begin
        rdy_d = 1'b1;
        st_d  = TMR_IDLE;
        per_d = '0;
      end else begin
        per_d = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TMR_IDLE;
      per_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      per_q <= per_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;

endmodule

// File: rtl/sync_clk_regen.sv
module sync_clk_regen #(
  parameter int DIV_RATIO    = 8,
  parameter int READY_CYCLES = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic div_clk_o,
  output logic sync_o,
  output logic data_ready_o
);

  logic realign;
  logic wrap;
  logic sync_neg_q;

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .rise_o  (realign)
  );

  phase_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .realign_i (realign),
    .div_clk_o (div_clk_o),
    .wrap_o    (wrap)
  );

  ready_timer #(.READY_CYCLES(READY_CYCLES)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (realign),
    .tick_i    (wrap),
    .ready_o   (data_ready_o)
  );

  // falling-edge launch: output sync straddles the realigning rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_neg_q <= 1'b0;
    else         sync_neg_q <= realign;
  end

  assign sync_o = sync_neg_q;

endmodule

// File: rtl/sync_clk_regen_chk.sv
module sync_clk_regen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_clk_o,
  input logic sync_o,
  input logic data_ready_o
);

  AST_SYNC_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o); // R5

  AST_REALIGN_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> div_clk_o); // R3

  AST_READY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |=> !data_ready_o); // R6

  AST_READY_ON_DIV_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> $rose(div_clk_o)); // R6

  AST_NO_READY_WITH_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !data_ready_o); // R7

endmodule

bind sync_clk_regen sync_clk_regen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .div_clk_o    (div_clk_o),
  .sync_o       (sync_o),
  .data_ready_o (data_ready_o)
);

// File: tb/sync_clk_regen_tb.sv
module sync_clk_regen_tb;

  localparam int DIV   = 6;
  localparam int READY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic div_clk, sync_out, rdy;

  int checks = 0;
  int errors = 0;

  // reference model state
  int hist[$];
  int ph;
  int armed;
  int per;
  int exp_div, exp_sync_pos, exp_sync_neg, exp_rdy;
  int rdy_seen;

  always #5 clk = ~clk;

  sync_clk_regen #(.DIV_RATIO(DIV), .READY_CYCLES(READY), .SYNC_STAGES(2)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_i       (sync_in),
    .div_clk_o    (div_clk),
    .sync_o       (sync_out),
    .data_ready_o (rdy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    hist = '{0, 0, 0, 0};
    ph = DIV - 1;
    armed = 0;
    per = 0;
    exp_div = 0;
    exp_sync_pos = 0;
    exp_sync_neg = 0;
    exp_rdy = 0;
  endtask

  initial model_reset();

  // behavioural model, advanced and compared on every rising edge
  always @(posedge clk) begin
    int v, r, realign, wrap;
    v = sync_in;
    r = rst_n;
    #2;
    if (!r) begin
      model_reset();
      chk("R1", "div_clk in reset", div_clk, 0);
      chk("R1", "sync_o in reset", sync_out, 0);
      chk("R1", "data_ready in reset", rdy, 0);
    end else begin
      hist.push_front(v);
      void'(hist.pop_back());
      realign = (hist[2] == 1 && hist[3] == 0) ? 1 : 0;
      wrap = (!realign && ph == DIV - 1) ? 1 : 0;
      ph = realign ? 0 : (ph + 1) % DIV;
      exp_div = (ph < DIV / 2) ? 1 : 0;
      exp_sync_pos = realign;
      exp_rdy = 0;
      if (realign) begin
        armed = 1;
        per = 0;
      end else if (wrap && armed) begin
        if (per == READY - 1) begin
          exp_rdy = 1;
          armed = 0;
        end else per++;
      end
      exp_sync_neg = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      chk("R2/R3", "div_clk at rising edge", div_clk, exp_div);
      chk("R5", "sync_o at rising edge", sync_out, exp_sync_pos);
      chk("R6/R7", "data_ready", rdy, exp_rdy);
      if (rdy) rdy_seen++;
    end
  end

  // falling-edge view: divider must hold, sync must already have switched
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      chk("R1", "sync_o in reset (fall)", sync_out, 0);
    end else begin
      chk("R5", "sync_o after falling edge", sync_out, exp_sync_neg);
      chk("R2", "div_clk held over falling edge", div_clk, exp_div);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #4;
  endtask

  task automatic pulse(input int width);
    sync_in = 1'b1;
    cycles(width);
    sync_in = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(4);
    rst_n = 1'b1;
    // R8: free running, no sync, no ready strobe
    rdy_seen = 0;
    cycles(3 * DIV * READY);
    chk("R8", "ready count without sync", rdy_seen, 0);

    // R3/R6: single-cycle sync, then full countdown
    rdy_seen = 0;
    pulse(1);
    cycles(DIV * READY + 20);
    chk("R6", "ready count after one sync", rdy_seen, 1);
    cycles(DIV * READY + 10);
    chk("R8", "no second strobe from one sync", rdy_seen, 1);

    // R4: long high level realigns once
    rdy_seen = 0;
    cycles(3);
    sync_in = 1'b1;
    cycles(2 * DIV * READY + 30);
    chk("R4", "ready count with held sync", rdy_seen, 1);
    sync_in = 1'b0;
    cycles(10);

    // R7: restart inside a countdown
    rdy_seen = 0;
    pulse(1);
    cycles(DIV * READY / 2);
    pulse(2);
    cycles(DIV * READY / 2 + 10);
    chk("R7", "no stale strobe before restart expires", rdy_seen, 0);
    cycles(DIV * READY / 2 + 20);
    chk("R7", "one strobe after restart", rdy_seen, 1);

    // R3: realign at every divider phase offset
    for (int k = 0; k < DIV; k++) begin
      pulse(1);
      cycles(3 * DIV + k + 1);
    end
    // back-to-back rises separated by one low cycle
    pulse(1);
    cycles(1);
    pulse(1);
    cycles(DIV * READY + 20);

    // R1: reset mid-run
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2 * DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule